// File: doc/BRIEF.md
# Three-Bus Multicycle Processor Core

This block is a compact 16-bit processor core. Its datapath is organised around three internal buses. Two operand buses feed an ALU, and the ALU result goes out on a single destination bus. Any register whose load enable is raised in that cycle captures the destination bus. There is no other path between registers: a copy from one register to another is made by the ALU passing one operand through unchanged. A control state machine takes each instruction through fetch, decode with register read, and execute. Some instructions need a few further cycles for write-back or for the memory access.

Instructions are 16 bits wide and use fixed fields:

| Bits | Field |
|------|-------|
| [15:12] | opcode |
| [11:9] | destination register |
| [8:6] | first source register |
| [5:3] | second source register |
| [5:0] | signed 6-bit offset |

The second source and the offset share the low bits. Memory is word addressed, so the program counter steps by one per instruction. The core drives a single synchronous memory port. The address always comes from the memory address register, and the write data always comes from the memory data register. Read data is taken one cycle after the read strobe.

A system places a program at word 0 and releases reset. The core then runs until it executes the halt opcode, and the results it produces can be seen in the memory writes it issues.

Top module: `tribus_cpu`

## Requirements
- R1: While the reset pin is low, mem_rd_o, mem_wr_o and halted_o are low. After release, the first memory access is a read of word address 0, with mem_rd_o high in the third cycle after the release edge.
- R2: Each instruction is fetched from the program counter, and the counter is increased by 1 during decode. An instruction occupies 6 cycles if it writes a register through the ALU, 7 for a store, 8 for a load and 5 for a branch.
- R3: Opcodes 0 to 7 compute rd = rs1 AND rs2, OR, XOR, NOT rs1, rs1 + rs2, rs1 - rs2, rs1 (move), and rs1 + sign-extended offset, respectively.
- R4: Register r0 always reads as zero. An instruction that names r0 as its destination leaves it zero.
- R5: The flags Z (result zero), N (result bit 15) and C are written only by opcodes 0 to 7. C is the carry out for add and add-immediate, 1 for subtract when there is no borrow, and 0 otherwise. All other opcodes leave the flags unchanged.
- R6: Opcodes A, B, C and D branch when Z=1, Z=0, C=1 and N=1, respectively. The target is the branch address + 1 + sign-extended offset. When the condition fails, execution continues at the next word.
- R7: Opcode 8 loads rd from address rs1 + sign-extended offset. Opcode 9 stores register rd (the bits [11:9] field) to that address. Only the low address bits reach the port.
- R8: Opcode E writes rd with the word address of the instruction itself. Like the move, it reaches the register only through an ALU pass.
- R9: Opcode F stops the core. halted_o rises 5 cycles after the halt fetch starts and stays high, and no memory access follows.
- R10: mem_rd_o and mem_wr_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| mem_addr_o | output | AW (8) | Memory word address, from the memory address register |
| mem_rd_o | output | 1 | Read strobe; data expected on mem_rdata_i the next cycle |
| mem_wr_o | output | 1 | Write strobe for mem_wdata_o at mem_addr_o |
| mem_wdata_o | output | DW (16) | Write data, from the memory data register |
| mem_rdata_i | input | DW (16) | Read data returned by memory |
| halted_o | output | 1 | High once the halt opcode has executed |

## Verification
The bench models the core's cycle costs. From these it predicts the exact cycle of every result.

- The internal reset lifts two edges after the pin, so the first instruction starts in cycle 2 and its fetch read appears in cycle 3.
- A store's write strobe is due 6 cycles after its own fetch starts.
- halted_o is due 5 cycles after the halt fetch starts.
- A skipped branch shadow contributes no cycles to the running count.

Each expected store is pushed into a queue together with its address, data and due cycle. A monitor samples on the falling edge and pops one entry per write strobe, so a wrong value, a wrong order, an extra store, a missing store or a late store each shows up as a mismatch.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  typedef enum logic [3:0] {
    OPC_AND  = 4'h0,
    OPC_OR   = 4'h1,
    OPC_XOR  = 4'h2,
    OPC_NOT  = 4'h3,
    OPC_ADD  = 4'h4,
    OPC_SUB  = 4'h5,
    OPC_MOV  = 4'h6,
    OPC_ADDI = 4'h7,
    OPC_LD   = 4'h8,
    OPC_ST   = 4'h9,
    OPC_BZ   = 4'hA,
    OPC_BNZ  = 4'hB,
    OPC_BCS  = 4'hC,
    OPC_BMI  = 4'hD,
    OPC_RIA  = 4'hE,
    OPC_HALT = 4'hF
  } opc_e;

  typedef enum logic [3:0] {
    ALU_PASS_A = 4'h0,
    ALU_PASS_B = 4'h1,
    ALU_AND    = 4'h2,
    ALU_OR     = 4'h3,
    ALU_XOR    = 4'h4,
    ALU_NOT    = 4'h5,
    ALU_ADD    = 4'h6,
    ALU_SUB    = 4'h7,
    ALU_INC    = 4'h8
  } alu_op_e;

  typedef enum logic [2:0] {
    OP1_A    = 3'd0,
    OP1_PC   = 3'd1,
    OP1_TEMP = 3'd2,
    OP1_MDR  = 3'd3,
    OP1_IAR  = 3'd4
  } op1_sel_e;

  typedef enum logic [1:0] {
    OP2_B    = 2'd0,
    OP2_IMM  = 2'd1,
    OP2_ZERO = 2'd2
  } op2_sel_e;

  typedef enum logic [3:0] {
    S_F_MAR  = 4'd0,
    S_F_RD   = 4'd1,
    S_F_IR   = 4'd2,
    S_DEC    = 4'd3,
    S_EXE    = 4'd4,
    S_ALU_WB = 4'd5,
    S_ST_MDR = 4'd6,
    S_ST_WR  = 4'd7,
    S_LD_RD  = 4'd8,
    S_LD_MDR = 4'd9,
    S_LD_WB  = 4'd10,
    S_HALT   = 4'd11
  } state_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } flags_t;

  typedef struct packed {
    op1_sel_e op1_sel;
    op2_sel_e op2_sel;
    alu_op_e  alu_op;
    logic     ld_mar;
    logic     ld_iar;
    logic     ld_pc;
    logic     ld_temp;
    logic     ld_mdr_bus;
    logic     ld_mdr_mem;
    logic     ld_ir;
    logic     ld_ab;
    logic     ld_flags;
    logic     rf_we;
    logic     mem_rd;
    logic     mem_wr;
  } ctrl_t;

endpackage

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] op1_i,
  input  logic [DW-1:0] op2_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] res_o,
  output flags_t        flags_o
);

  logic [DW:0] wide;

  always_comb begin
    wide = '0;
    unique case (op_i)
      ALU_PASS_A: wide = {1'b0, op1_i};
      ALU_PASS_B: wide = {1'b0, op2_i};
      ALU_AND:    wide = {1'b0, op1_i & op2_i};
      ALU_OR:     wide = {1'b0, op1_i | op2_i};
      ALU_XOR:    wide = {1'b0, op1_i ^ op2_i};
      ALU_NOT:    wide = {1'b0, ~op1_i};
      ALU_ADD:    wide = {1'b0, op1_i} + {1'b0, op2_i};
      ALU_SUB:    wide = {1'b0, op1_i} + {1'b0, ~op2_i} + {{DW{1'b0}}, 1'b1};
      ALU_INC:    wide = {1'b0, op1_i} + {{DW{1'b0}}, 1'b1};
      default:    wide = '0;
    endcase
  end

  assign res_o     = wide[DW-1:0];
  assign flags_o.z = (wide[DW-1:0] == '0);
  assign flags_o.n = wide[DW-1];
  assign flags_o.c = wide[DW];

endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [RAW-1:0] raddr_a_i,
  input  logic [RAW-1:0] raddr_b_i,
  output logic [DW-1:0]  rdata_a_o,
  output logic [DW-1:0]  rdata_b_o
);

  logic [DW-1:0] regs_q [NREG];
  logic          wr_ok;

  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_ok) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  assert_r0_zero_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));

endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [3:0] opc_i,
  input  flags_t     flags_i,
  output ctrl_t      ctl_o,
  output state_e     state_o
);

  state_e state_q, state_d;
  opc_e   opc;
  logic   take;

  assign opc = opc_e'(opc_i);

  always_comb begin
    unique case (opc)
      OPC_BZ:  take = flags_i.z;
      OPC_BNZ: take = !flags_i.z;
      OPC_BCS: take = flags_i.c;
      OPC_BMI: take = flags_i.n;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    ctl_o   = '0;
    state_d = state_q;
    unique case (state_q)
      S_F_MAR: begin
        ctl_o.op1_sel = OP1_PC;
        ctl_o.alu_op  = ALU_PASS_A;
        ctl_o.ld_mar  = 1'b1;
        ctl_o.ld_iar  = 1'b1;
        state_d       = S_F_RD;
      end
      S_F_RD: begin
        ctl_o.mem_rd = 1'b1;
        state_d      = S_F_IR;
      end
      S_F_IR: begin
        ctl_o.ld_ir = 1'b1;
        state_d     = S_DEC;
      end
      S_DEC: begin
        ctl_o.ld_ab   = 1'b1;
        ctl_o.op1_sel = OP1_PC;
        ctl_o.alu_op  = ALU_INC;
        ctl_o.ld_pc   = 1'b1;
        state_d       = S_EXE;
      end
      S_EXE: begin
        unique case (opc)
          OPC_AND, OPC_OR, OPC_XOR, OPC_NOT,
          OPC_ADD, OPC_SUB, OPC_MOV, OPC_ADDI: begin
            ctl_o.op1_sel  = OP1_A;
            ctl_o.op2_sel  = (opc == OPC_ADDI) ? OP2_IMM : OP2_B;
            ctl_o.ld_temp  = 1'b1;
            ctl_o.ld_flags = 1'b1;
            unique case (opc)
              OPC_AND: ctl_o.alu_op = ALU_AND;
              OPC_OR:  ctl_o.alu_op = ALU_OR;
              OPC_XOR: ctl_o.alu_op = ALU_XOR;
              OPC_NOT: ctl_o.alu_op = ALU_NOT;
              OPC_SUB: ctl_o.alu_op = ALU_SUB;
              OPC_MOV: ctl_o.alu_op = ALU_PASS_A;
              default: ctl_o.alu_op = ALU_ADD;
            endcase
            state_d = S_ALU_WB;
          end
          OPC_RIA: begin
            ctl_o.op1_sel = OP1_IAR;
            ctl_o.alu_op  = ALU_PASS_A;
            ctl_o.ld_temp = 1'b1;
            state_d       = S_ALU_WB;
          end
          OPC_LD, OPC_ST: begin
            ctl_o.op1_sel = OP1_A;
            ctl_o.op2_sel = OP2_IMM;
            ctl_o.alu_op  = ALU_ADD;
            ctl_o.ld_mar  = 1'b1;
            state_d       = (opc == OPC_LD) ? S_LD_RD : S_ST_MDR;
          end
          OPC_BZ, OPC_BNZ, OPC_BCS, OPC_BMI: begin
            ctl_o.op1_sel = OP1_PC;
            ctl_o.op2_sel = OP2_IMM;
            ctl_o.alu_op  = ALU_ADD;
            ctl_o.ld_pc   = take;
            state_d       = S_F_MAR;
          end
          default: state_d = S_HALT;
        endcase
      end
      S_ALU_WB: begin
        ctl_o.op1_sel = OP1_TEMP;
        ctl_o.alu_op  = ALU_PASS_A;
        ctl_o.rf_we   = 1'b1;
        state_d       = S_F_MAR;
      end
      S_ST_MDR: begin
        ctl_o.op2_sel    = OP2_B;
        ctl_o.alu_op     = ALU_PASS_B;
        ctl_o.ld_mdr_bus = 1'b1;
        state_d          = S_ST_WR;
      end
      S_ST_WR: begin
        ctl_o.mem_wr = 1'b1;
        state_d      = S_F_MAR;
      end
      S_LD_RD: begin
        ctl_o.mem_rd = 1'b1;
        state_d      = S_LD_MDR;
      end
      S_LD_MDR: begin
        ctl_o.ld_mdr_mem = 1'b1;
        state_d          = S_LD_WB;
      end
      S_LD_WB: begin
        ctl_o.op1_sel = OP1_MDR;
        ctl_o.alu_op  = ALU_PASS_A;
        ctl_o.rf_we   = 1'b1;
        state_d       = S_F_MAR;
      end
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_F_MAR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_HALT) |=> (state_q == S_HALT) && !ctl_o.mem_rd && !ctl_o.mem_wr);

endmodule

// File: rtl/tribus_cpu.sv
module tribus_cpu
  import tribus_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 8,
  parameter int unsigned NREG = 8,
  localparam int unsigned RAW  = $clog2(NREG),
  localparam int unsigned OFFW = 6
) (
  input  logic          clk,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          halted_o
);

  // reset: asserted at once, lifted two edges after the pin
  logic rst_meta_q, rst_sync_q, rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n = rst_sync_q;

  logic [AW-1:0]   pc_q, iar_q, mar_q;
  logic [DW-1:0]   ir_q, a_q, b_q, temp_q, mdr_q;
  flags_t          flags_q, alu_flags;
  logic [DW-1:0]   op1_bus, op2_bus, dest_bus, imm;
  logic [DW-1:0]   rf_a, rf_b;
  logic [RAW-1:0]  f_rd, f_rs1, f_rs2, rf_raddr_b;
  logic [3:0]      f_opc;
  logic [OFFW-1:0] f_off;
  ctrl_t           ctl;
  state_e          state;

  assign f_opc = ir_q[15:12];
  assign f_rd  = ir_q[11:9];
  assign f_rs1 = ir_q[8:6];
  assign f_rs2 = ir_q[5:3];
  assign f_off = ir_q[OFFW-1:0];
  assign imm   = {{(DW-OFFW){f_off[OFFW-1]}}, f_off};

  assign rf_raddr_b = (f_opc == OPC_ST) ? f_rd : f_rs2;

  tribus_ctrl u_ctrl (
    .clk     (clk),
    .rst_ni  (rst_n),
    .opc_i   (f_opc),
    .flags_i (flags_q),
    .ctl_o   (ctl),
    .state_o (state)
  );

  tribus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_ni    (rst_n),
    .we_i      (ctl.rf_we),
    .waddr_i   (f_rd),
    .wdata_i   (dest_bus),
    .raddr_a_i (f_rs1),
    .raddr_b_i (rf_raddr_b),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b)
  );

  // operand buses
  always_comb begin
    unique case (ctl.op1_sel)
      OP1_PC:   op1_bus = {{(DW-AW){1'b0}}, pc_q};
      OP1_TEMP: op1_bus = temp_q;
      OP1_MDR:  op1_bus = mdr_q;
      OP1_IAR:  op1_bus = {{(DW-AW){1'b0}}, iar_q};
      default:  op1_bus = a_q;
    endcase
    unique case (ctl.op2_sel)
      OP2_IMM:  op2_bus = imm;
      OP2_ZERO: op2_bus = '0;
      default:  op2_bus = b_q;
    endcase
  end

  tribus_alu #(.DW(DW)) u_alu (
    .op1_i   (op1_bus),
    .op2_i   (op2_bus),
    .op_i    (ctl.alu_op),
    .res_o   (dest_bus),
    .flags_o (alu_flags)
  );

  // registers listening to the destination bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      iar_q  <= '0;
      mar_q  <= '0;
      temp_q <= '0;
      mdr_q  <= '0;
    end else begin
      if (ctl.ld_pc)           pc_q   <= dest_bus[AW-1:0];
      if (ctl.ld_iar)          iar_q  <= dest_bus[AW-1:0];
      if (ctl.ld_mar)          mar_q  <= dest_bus[AW-1:0];
      if (ctl.ld_temp)         temp_q <= dest_bus;
      if (ctl.ld_mdr_bus)      mdr_q  <= dest_bus;
      else if (ctl.ld_mdr_mem) mdr_q  <= mem_rdata_i;
    end
  end

  // instruction, operand latches, status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      flags_q <= '0;
    end else begin
      if (ctl.ld_ir) ir_q <= mem_rdata_i;
      if (ctl.ld_ab) begin
        a_q <= rf_a;
        b_q <= rf_b;
      end
      if (ctl.ld_flags) begin
        flags_q.z <= alu_flags.z;
        flags_q.n <= alu_flags.n;
        flags_q.c <= (ctl.alu_op == ALU_ADD || ctl.alu_op == ALU_SUB) ? alu_flags.c : 1'b0;
      end
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_rd_o    = ctl.mem_rd;
  assign mem_wr_o    = ctl.mem_wr;
  assign halted_o    = (state == S_HALT);

  assert_rw_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC) |=> (pc_q == $past(pc_q) + 1'b1));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXE && f_opc[3]) |=> $stable(flags_q));

  assert_br_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXE && f_opc == OPC_BZ && !flags_q.z) |=> $stable(pc_q));

endmodule

// File: tb/tribus_cpu_tb.sv
`timescale 1ns/1ps
module tribus_cpu_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  tribus_cpu u_dut (
    .clk         (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halted_o    (halted)
  );

  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  int cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct {
    int          addr;
    logic [15:0] data;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int ptr = 0, model_cyc = 2, halt_due = -1;
  int post_halt_acc = 0;
  bit seen_rd = 0, seen_halt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] rr(input logic [3:0] op, input int rd, input int s1, input int s2);
    return {op, 3'(rd), 3'(s1), 3'(s2), 3'b000};
  endfunction
  function automatic logic [15:0] ri(input logic [3:0] op, input int rd, input int s1, input logic [5:0] off);
    return {op, 3'(rd), 3'(s1), off};
  endfunction

  task automatic put(input logic [15:0] w, input int cost);
    mem[ptr] = w;
    ptr++;
    model_cyc += cost;
  endtask

  // store driver: pushes the predicted write then places the instruction
  task automatic st(input int rd, input int base, input logic [5:0] off,
                    input int addr, input logic [15:0] data, input string tag);
    exp_t e;
    e.addr = addr; e.data = data; e.due = model_cyc + 6; e.tag = tag;
    q.push_back(e);
    put(ri(4'h9, rd, base, off), 7);
  endtask

  // monitor: falling edge, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_rd && !seen_rd) begin
          seen_rd = 1;
          check(cyc == 3, "R1", "first read cycle", cyc, 3);
          check(mem_addr == 8'h00, "R1", "first read address", mem_addr, 0);
        end
        if (mem_wr) begin
          if (q.size() == 0) begin
            check(0, "R7", "unexpected store addr", mem_addr, -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(mem_addr == e.addr[7:0], e.tag, "store address", mem_addr, e.addr);
            check(mem_wdata == e.data, e.tag, "store data", mem_wdata, e.data);
            check(cyc == e.due, "R2", "store cycle", cyc, e.due);
          end
        end
        if (seen_halt && (mem_rd || mem_wr)) post_halt_acc++;
        if (halted && !seen_halt) begin
          seen_halt = 1;
          check(cyc == halt_due, "R9", "halt cycle", cyc, halt_due);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // program: store targets sit at 0xE0+k via r0 + (-32+k)
    put(ri(4'h7, 1, 0, 6'd5), 6);              // r1 = 5            R3
    put(ri(4'h7, 2, 0, 6'h3D), 6);             // r2 = FFFD
    put(rr(4'h4, 3, 1, 2), 6);                 // r3 = 2, C=1       R3 R5
    put(ri(4'hC, 0, 0, 6'd1), 5);              // BCS taken         R6
    put(ri(4'h9, 1, 0, 6'h20), 0);             // skipped
    st(3, 0, 6'h21, 8'hE1, 16'h0002, "R3");
    put(rr(4'h5, 4, 1, 1), 6);                 // r4 = 0, Z=1
    put(ri(4'hB, 0, 0, 6'd1), 5);              // BNZ not taken     R6
    st(4, 0, 6'h22, 8'hE2, 16'h0000, "R6");
    put(ri(4'hA, 0, 0, 6'd1), 5);              // BZ taken, flags held by ST  R5
    put(ri(4'h9, 1, 0, 6'h23), 0);             // skipped
    put(rr(4'h0, 5, 1, 2), 6);
    st(5, 0, 6'h23, 8'hE3, 16'h0005, "R3");
    put(rr(4'h1, 5, 1, 2), 6);
    st(5, 0, 6'h24, 8'hE4, 16'hFFFD, "R3");
    put(rr(4'h2, 5, 1, 2), 6);
    st(5, 0, 6'h25, 8'hE5, 16'hFFF8, "R3");
    put(rr(4'h3, 5, 1, 0), 6);                 // NOT -> FFFA, N=1
    put(ri(4'hD, 0, 0, 6'd1), 5);              // BMI taken         R6
    put(ri(4'h9, 1, 0, 6'h20), 0);             // skipped
    st(5, 0, 6'h26, 8'hE6, 16'hFFFA, "R3");
    put(rr(4'h5, 6, 1, 2), 6);                 // 5-FFFD = 8, borrow -> C=0  R5
    put(ri(4'hC, 0, 0, 6'd1), 5);              // BCS not taken
    st(6, 0, 6'h27, 8'hE7, 16'h0008, "R5");
    put(rr(4'h6, 6, 2, 0), 6);                 // MOV               R8
    st(6, 0, 6'h28, 8'hE8, 16'hFFFD, "R8");
    put(ri(4'h7, 0, 1, 6'd7), 6);              // write to r0       R4
    st(0, 0, 6'h29, 8'hE9, 16'h0000, "R4");
    put(rr(4'h4, 6, 0, 1), 6);
    st(6, 0, 6'h2A, 8'hEA, 16'h0005, "R4");
    put(ri(4'h8, 7, 0, 6'h25), 8);             // LD r7 <- [E5]     R7
    st(7, 0, 6'h2B, 8'hEB, 16'hFFF8, "R7");
    put(ri(4'h7, 3, 0, 6'h22), 6);             // r3 = FFE2
    put(ri(4'h8, 7, 3, 6'd2), 8);              // LD r7 <- [E4]
    st(7, 3, 6'd10, 8'hEC, 16'hFFFD, "R7");
    begin
      logic [15:0] here;
      here = 16'(ptr);
      put(ri(4'hE, 6, 0, 6'd0), 6);            // own address       R8
      st(6, 0, 6'h2D, 8'hED, here, "R8");
    end
    halt_due = model_cyc + 5;
    put(16'hF000, 5);                          // HALT              R9
    put(ri(4'h9, 1, 0, 6'h2E), 0);             // never reached

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!mem_rd && !mem_wr, "R1", "port idle in reset", {mem_rd, mem_wr}, 0);
    check(!halted, "R1", "halted low in reset", halted, 0);
    rst_n = 1'b1;

    while (!halted && cyc < 5000) @(negedge clk);
    check(halted, "R9", "watchdog: halt reached", halted, 1);
    repeat (20) @(negedge clk);
    check(halted, "R9", "halted stays high", halted, 1);
    check(post_halt_acc == 0, "R9", "accesses after halt", post_halt_acc, 0);
    check(q.size() == 0, "R7", "stores still pending", q.size(), 0);
    check(seen_rd, "R1", "fetch seen", seen_rd, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule